// File: doc/BRIEF.md
# Multi-Lane Pixel Deserializer with Parity Check

This block takes a serialized video stream arriving on one, two or three single-ended data lanes. A bit clock samples the lanes, and a strobe marks the first bit-clock beat of every 30-bit frame. Each frame is collected into one shift register and checked for its start marker, its stop marker and its even parity bit. The 24 pixel bits and 3 control bits are then written to a registered parallel output. A frame that fails any check leaves the previous word on the output and raises a one-cycle error pulse.

A lane-count setting selects 30, 15 or 10 beats per frame. A swap input reverses the lane order, so that board routing can be flipped. A power-state input gates the output register: in standby or shutdown the outputs are held at zero, and any partly received frame is dropped.

Top module: `pixel_lane_deser`

## Requirements
- R1: During reset, the cycle after reset is released, and until the first good frame completes, `pix_out` and `ctl_out` are zero and `perr` is low.
- R2: A frame has 30 bits, numbered 0 to 29. Bit 0 is a start marker of 1. Bits 1..24 are `pix_out[0..23]`. Bits 25..27 are `ctl_out[0..2]`. Bit 28 is even parity over bits 1..27. Bit 29 is a stop marker of 0. A good frame appears on the outputs at the clock edge that samples its last beat.
- R3: `lane_cfg` selects the lane count: 0 gives 1 lane and 30 beats, 1 gives 2 lanes and 15 beats, 2 or 3 gives 3 lanes and 10 beats. On beat b, logical lane k carries frame bit b*L+k.
- R4: With `swap_lanes` high, logical lane k is taken from physical lane L-1-k.
- R5: A frame whose parity bit is wrong raises `perr` for exactly one cycle and leaves the previous word on the outputs.
- R6: A frame with a wrong start or stop marker is treated like a parity failure: a one-cycle `perr`, and the outputs are held.
- R7: Physical lanes at or above the selected lane count have no effect on the outputs.
- R8: A frame begins only on a beat with `sync` high. Beats outside a frame have no effect.
- R9: `pwr_mode` 0 is active. 1 is standby, and 2 or 3 is shutdown. In any non-active state, the edge clears the outputs and `perr` and drops any partial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_cfg | input | 2 | Lane count select |
| swap_lanes | input | 1 | Reverse lane order |
| pwr_mode | input | 2 | Power state: 0 active, 1 standby, 2/3 shutdown |
| sync | input | 1 | High on the first beat of a frame |
| lane_in | input | 3 | Serial data lanes |
| pix_out | output | 24 | Registered pixel bits |
| ctl_out | output | 3 | Registered control bits |
| perr | output | 1 | One-cycle frame error pulse |

## Verification
Frames with walking and mixed payloads are sent at every lane count, with and without swap, so that a bit landing in the wrong lane or slot shows up as a wrong output bit. Corrupted parity, start and stop bits each test the hold-and-flag path against the good path. Toggling unused lanes, idle beats without sync, and a standby break in the middle of a frame separate real frame data from stray activity. A behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/pixel_lane_deser.sv
module pixel_lane_deser #(
  parameter int FRAME_W = 30,
  parameter int LANES   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  lane_cfg,
  input  logic        swap_lanes,
  input  logic [1:0]  pwr_mode,
  input  logic        sync,
  input  logic [2:0]  lane_in,
  output logic [23:0] pix_out,
  output logic [2:0]  ctl_out,
  output logic        perr
);
  localparam int CW = $clog2(FRAME_W + 1);
  localparam int PW = FRAME_W - 3;

  logic [FRAME_W-1:0] sr, cur;
  logic [PW-1:0]      word;
  logic [CW-1:0]      cnt, bi, last;
  logic [1:0]         nl;
  logic [LANES-1:0]   lb;
  logic               busy, act, done, ok;

  assign act  = (pwr_mode == 2'd0);
  assign nl   = (lane_cfg == 2'd0) ? 2'd1 : (lane_cfg == 2'd1) ? 2'd2 : 2'd3;
  assign last = CW'(FRAME_W / int'(nl) - 1);
  assign bi   = sync ? '0 : cnt;
  assign done = (sync | busy) && (bi == last);

  always_comb begin
    int src;
    lb = '0;
    for (int k = 0; k < LANES; k++) begin
      src = swap_lanes ? int'(nl) - 1 - k : k;
      if (k < int'(nl) && src >= 0 && src < LANES) lb[k] = lane_in[src];
    end
  end

  always_comb begin
    int pos;
    cur = sr;
    for (int k = 0; k < LANES; k++) begin
      pos = int'(bi) * int'(nl) + k;
      if (k < int'(nl) && pos < FRAME_W) cur[pos] = lb[k];
    end
  end

  assign ok = cur[0] && !cur[FRAME_W-1] && !(^cur[FRAME_W-2:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; cnt <= '0; busy <= 1'b0; word <= '0; perr <= 1'b0;
    end else if (!act) begin
      sr <= '0; cnt <= '0; busy <= 1'b0; word <= '0; perr <= 1'b0;
    end else begin
      perr <= 1'b0;
      if (sync | busy) begin
        sr   <= cur;
        cnt  <= bi + 1'b1;
        busy <= !done;
      end
      if (done) begin
        if (ok) word <= cur[PW:1];
        else    perr <= 1'b1;
      end
    end
  end

  assign pix_out = word[23:0];
  assign ctl_out = word[26:24];
endmodule

// File: rtl/pixel_lane_deser_chk.sv
module pixel_lane_deser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  pwr_mode,
  input logic [23:0] pix_out,
  input logic [2:0]  ctl_out,
  input logic        perr
);
  // R5
  perr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr |=> !perr);
  // R5
  hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> $stable({ctl_out, pix_out}));
  // R9
  lowpwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'd0) |=> (pix_out == '0 && ctl_out == '0 && !perr));
  // R6
  change_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable({ctl_out, pix_out}) && $past(pwr_mode) == 2'd0) |-> !perr);
  // R9
  err_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr |-> $past(pwr_mode) == 2'd0);
endmodule

bind pixel_lane_deser pixel_lane_deser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode),
  .pix_out(pix_out), .ctl_out(ctl_out), .perr(perr)
);

// File: tb/pixel_lane_deser_tb.sv
module pixel_lane_deser_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] lane_cfg = 2'd0, pwr_mode = 2'd0;
  logic swap_lanes = 1'b0, sync = 1'b0;
  logic [2:0] lane_in = 3'b000;
  logic [23:0] pix_out;
  logic [2:0] ctl_out;
  logic perr;

  int checks = 0, failures = 0;
  logic [26:0] ew = '0;
  logic ep = 1'b0;
  string req = "R1";

  pixel_lane_deser u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare();
    checks++;
    if ({ctl_out, pix_out} !== ew || perr !== ep) begin
      failures++;
      $display("FAIL %s: word=%h perr=%b expected word=%h perr=%b",
               req, {ctl_out, pix_out}, perr, ew, ep);
    end
  endtask

  function automatic logic [29:0] mk(input logic [26:0] pl, input int bad);
    logic [29:0] f;
    f = {1'b0, ^pl, pl, 1'b1};
    if (bad == 1) f[28] = ~f[28];
    if (bad == 2) f[0]  = 1'b0;
    if (bad == 3) f[29] = 1'b1;
    return f;
  endfunction

  function automatic int nlanes(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 3;
  endfunction

  task automatic beat(input logic [2:0] ln, input logic s, input logic [1:0] pm,
                      input bit fin, input logic [29:0] f);
    lane_in = ln; sync = s; pwr_mode = pm;
    @(posedge clk); #1;
    ep = 1'b0;
    if (pm != 2'd0) ew = '0;
    else if (fin) begin
      if (f[0] && !f[29] && !(^f[28:1])) ew = f[27:1];
      else ep = 1'b1;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic send(input logic [29:0] f, input int nbeats_max, input logic [2:0] junk);
    int L, nb;
    L = nlanes(lane_cfg);
    nb = 30 / L;
    for (int b = 0; b < nb && b < nbeats_max; b++) begin
      logic [2:0] ln;
      ln = junk;
      for (int k = 0; k < L; k++)
        ln[swap_lanes ? L-1-k : k] = f[b*L+k];
      beat(ln, b == 0, 2'd0, b == nb-1, f);
    end
  endtask

  task automatic idle(input int n, input logic [1:0] pm);
    for (int i = 0; i < n; i++) beat(3'(i * 5 + 3), 1'b0, pm, 1'b0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    req = "R1"; compare();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); compare();
    idle(3, 2'd0);

    // R2 R3: one lane, walking and mixed payloads
    req = "R3_1lane";
    for (int i = 0; i < 27; i += 5) send(mk(27'd1 << i, 0), 99, 3'b000);
    send(mk(27'h5A3C96F, 0), 99, 3'b000);
    // R7: unused lanes toggled high
    req = "R7";
    send(mk(27'h1234567, 0), 99, 3'b110);
    // R3: two and three lanes
    req = "R3_2lane"; lane_cfg = 2'd1;
    send(mk(27'h7ABCDEF, 0), 99, 3'b100);
    send(mk(27'h0F0F0F0, 0), 99, 3'b000);
    req = "R3_3lane"; lane_cfg = 2'd2;
    send(mk(27'h2468ACE, 0), 99, 3'b000);
    lane_cfg = 2'd3;
    send(mk(27'h13579BD, 0), 99, 3'b000);
    // R4: swap
    req = "R4"; swap_lanes = 1'b1;
    send(mk(27'h6DB6DB6, 0), 99, 3'b000);
    lane_cfg = 2'd1;
    send(mk(27'h0000FFF, 0), 99, 3'b100);
    swap_lanes = 1'b0;
    // R5 R6: corrupted frames hold output
    req = "R5"; send(mk(27'h7FFFFFF, 1), 99, 3'b000);
    idle(2, 2'd0);
    req = "R6_start"; send(mk(27'h3333333, 2), 99, 3'b000);
    req = "R6_stop"; lane_cfg = 2'd0;
    send(mk(27'h4444444, 3), 99, 3'b000);
    req = "R2"; send(mk(27'h4000001, 0), 99, 3'b000);
    // R8: idle beats without sync change nothing
    req = "R8"; idle(40, 2'd0);
    // R9: standby mid-frame drops the partial frame
    req = "R9"; lane_cfg = 2'd2;
    send(mk(27'h1111111, 0), 4, 3'b000);
    idle(3, 2'd1);
    idle(12, 2'd0);
    send(mk(27'h2222222, 0), 99, 3'b000);
    idle(2, 2'd2);
    req = "R1_resume"; idle(5, 2'd0);
    send(mk(27'h0ABCDEF, 0), 99, 3'b000);
    idle(2, 2'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule